// File: doc/BRIEF.md
# Debug Console Serial Receiver

This block receives asynchronous serial characters on one input line for a debug console. A free-running 16x sample enable sets the timing. The line first passes through a two-flop synchronizer. A falling edge arms start detection, and the start bit is accepted only if the line is still low half a bit later. After that the engine samples every following bit at mid-bit, one bit time apart: eight data bits with the least significant first, then a parity bit when parity is selected, then one stop bit.

Each finished character goes into a holding register, and a small status word reports it. The status word has four flags: ready, overrun, parity error and framing error. A read strobe takes the character and clears ready. A clear-status strobe clears the three error flags. A three-bit mode input selects the parity rule.

Top module: `dbg_rx`

## Requirements
- R1: A low level on the line counts as a start bit only if it is still low at the sample taken 8 sample ticks after it was first seen. A low pulse shorter than that produces no character and leaves `st_ready` at 0.
- R2: Data bits are sampled 16 ticks apart at mid-bit and are assembled least significant bit first, so the first data bit on the line appears in `rx_data[0]`.
- R3: When the stop bit has been sampled, the character is written to `rx_data` and `st_ready` is set to 1.
- R4: A one-cycle pulse on `rd_en` clears `st_ready` on the next clock edge and leaves `rx_data` unchanged.
- R5: If a character completes while `st_ready` is 1 and no read is strobed in that cycle, `st_overrun` is set, `rx_data` takes the new character and `st_ready` stays 1.
- R6: `st_overrun`, `st_parity_err` and `st_frame_err` stay set until a pulse on `clr_err`, which clears all three and does not change `st_ready` or `rx_data`.
- R7: The `parity_mode` input selects the parity rule. 3'b000 is even, so the parity bit equals the XOR of the data bits. 3'b001 is odd, so the parity bit is the inverse of that XOR. 3'b010 requires a parity bit of 0 and 3'b011 requires a parity bit of 1. A received parity bit that differs from the expected value sets `st_parity_err`.
- R8: With `parity_mode[2]` = 1 no parity bit is expected: the stop bit follows the last data bit directly and `st_parity_err` is not set.
- R9: A stop bit sampled low sets `st_frame_err`, and the character is still written to `rx_data` with `st_ready` set.
- R10: After reset `st_ready`, `st_overrun`, `st_parity_err`, `st_frame_err` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Sample enable at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| parity_mode | input | 3 | Parity rule selector |
| rd_en | input | 1 | Holding register read strobe |
| clr_err | input | 1 | Clear-status strobe for the error flags |
| rx_data | output | 8 | Receive holding register |
| st_ready | output | 1 | A character is waiting |
| st_overrun | output | 1 | A character arrived while ready was set |
| st_parity_err | output | 1 | Parity mismatch seen (sticky) |
| st_frame_err | output | 1 | Low stop bit seen (sticky) |

## Verification
A character becomes visible two clock edges after the tick that samples its stop bit. The first edge registers the frame engine's completion pulse, and the second updates the status register. The stop sample falls at mid-stop, up to about 8 clocks later than nominal because of the synchronizer and tick alignment. The bench therefore checks a character only after the whole stop bit and an idle gap have been driven. Read and clear strobes are applied for one cycle between falling edges, and their effect is checked at the next falling edge, one register stage later.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    localparam logic [2:0] PMODE_EVEN  = 3'b000;
    localparam logic [2:0] PMODE_ODD   = 3'b001;
    localparam logic [2:0] PMODE_SPACE = 3'b010;
    localparam logic [2:0] PMODE_MARK  = 3'b011;

endpackage

// File: rtl/dbg_rx_sync.sv
module dbg_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_rx_frame.sv
module dbg_rx_frame
    import dbg_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx,
    input  logic [2:0]           mode,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr,
    output logic                 ferr
);
    localparam int HALF = OSR / 2;
    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DATA_BITS);

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        idx;
        logic [DATA_BITS-1:0] sh;
        logic                 perr;
        logic                 ferr;
        logic                 done;
    } frame_t;

    frame_t fr_d, fr_q;

    function automatic logic par_ref(input logic [1:0] m, input logic [DATA_BITS-1:0] d);
        case (m)
            PMODE_EVEN[1:0]:  return ^d;
            PMODE_ODD[1:0]:   return ~^d;
            PMODE_SPACE[1:0]: return 1'b0;
            default:          return 1'b1;
        endcase
    endfunction

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        if (tick) begin
            case (fr_q.st)
                RX_IDLE: begin
                    if (!rx) begin
                        fr_d.st  = RX_START;
                        fr_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (fr_q.cnt == CW'(HALF - 1)) begin
                        fr_d.cnt = '0;
                        if (!rx) begin
                            fr_d.st   = RX_DATA;
                            fr_d.idx  = '0;
                            fr_d.perr = 1'b0;
                        end else begin
                            fr_d.st = RX_IDLE;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (fr_q.cnt == CW'(OSR - 1)) begin
                        fr_d.cnt = '0;
                        fr_d.sh  = {rx, fr_q.sh[DATA_BITS-1:1]};
                        if (fr_q.idx == BW'(DATA_BITS - 1))
                            fr_d.st = mode[2] ? RX_STOP : RX_PAR;
                        else
                            fr_d.idx = fr_q.idx + 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (fr_q.cnt == CW'(OSR - 1)) begin
                        fr_d.cnt  = '0;
                        fr_d.perr = rx ^ par_ref(mode[1:0], fr_q.sh);
                        fr_d.st   = RX_STOP;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (fr_q.cnt == CW'(OSR - 1)) begin
                        fr_d.cnt  = '0;
                        fr_d.ferr = !rx;
                        fr_d.done = 1'b1;
                        fr_d.st   = RX_IDLE;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                default: fr_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{st: RX_IDLE, default: '0};
        else        fr_q <= fr_d;
    end

    assign done = fr_q.done;
    assign data = fr_q.sh;
    assign perr = fr_q.perr;
    assign ferr = fr_q.ferr;
endmodule

// File: rtl/dbg_rx_status.sv
module dbg_rx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 char_done,
    input  logic [DATA_BITS-1:0] char_data,
    input  logic                 char_perr,
    input  logic                 char_ferr,
    input  logic                 rd_en,
    input  logic                 clr_err,
    output logic [DATA_BITS-1:0] hold,
    output logic                 ready,
    output logic                 ovr,
    output logic                 pe,
    output logic                 fe
);
    typedef struct packed {
        logic [DATA_BITS-1:0] hold;
        logic                 ready;
        logic                 ovr;
        logic                 pe;
        logic                 fe;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_err) begin
            st_d.ovr = 1'b0;
            st_d.pe  = 1'b0;
            st_d.fe  = 1'b0;
        end
        if (rd_en) st_d.ready = 1'b0;
        if (char_done) begin
            st_d.hold  = char_data;
            st_d.ready = 1'b1;
            if (st_q.ready && !rd_en) st_d.ovr = 1'b1;
            if (char_perr) st_d.pe = 1'b1;
            if (char_ferr) st_d.fe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold  = st_q.hold;
    assign ready = st_q.ready;
    assign ovr   = st_q.ovr;
    assign pe    = st_q.pe;
    assign fe    = st_q.fe;
endmodule

// File: rtl/dbg_rx.sv
module dbg_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_16x,
    input  logic                 rx_line,
    input  logic [2:0]           parity_mode,
    input  logic                 rd_en,
    input  logic                 clr_err,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 st_ready,
    output logic                 st_overrun,
    output logic                 st_parity_err,
    output logic                 st_frame_err
);
    logic                 rx_s;
    logic                 char_done;
    logic [DATA_BITS-1:0] char_data;
    logic                 char_perr;
    logic                 char_ferr;

    dbg_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    dbg_rx_frame #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_16x),
        .rx   (rx_s),
        .mode (parity_mode),
        .done (char_done),
        .data (char_data),
        .perr (char_perr),
        .ferr (char_ferr)
    );

    dbg_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_done(char_done),
        .char_data(char_data),
        .char_perr(char_perr),
        .char_ferr(char_ferr),
        .rd_en    (rd_en),
        .clr_err  (clr_err),
        .hold     (rx_data),
        .ready    (st_ready),
        .ovr      (st_overrun),
        .pe       (st_parity_err),
        .fe       (st_frame_err)
    );
endmodule

// File: rtl/dbg_rx_chk.sv
module dbg_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic                 clr_err,
    input logic                 char_done,
    input logic [DATA_BITS-1:0] char_data,
    input logic                 char_perr,
    input logic                 char_ferr,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 st_ready,
    input logic                 st_overrun,
    input logic                 st_parity_err,
    input logic                 st_frame_err
);
    a_r3_char_lands: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> st_ready && rx_data == $past(char_data));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !char_done |=> !st_ready && $stable(rx_data));

    a_r5_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && st_ready && !rd_en |=> st_overrun && st_ready);

    a_r6_errors_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err && (st_overrun || st_parity_err || st_frame_err) |=>
        (st_overrun >= $past(st_overrun)) && (st_parity_err >= $past(st_parity_err))
        && (st_frame_err >= $past(st_frame_err)));

    a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err && !char_done |=> !st_overrun && !st_parity_err && !st_frame_err);

    a_r7_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && char_perr |=> st_parity_err);

    a_r9_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && char_ferr |=> st_frame_err && st_ready);
endmodule

bind dbg_rx dbg_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .clr_err      (clr_err),
    .char_done    (char_done),
    .char_data    (char_data),
    .char_perr    (char_perr),
    .char_ferr    (char_ferr),
    .rx_data      (rx_data),
    .st_ready     (st_ready),
    .st_overrun   (st_overrun),
    .st_parity_err(st_parity_err),
    .st_frame_err (st_frame_err)
);

// File: tb/dbg_rx_tb.sv
`timescale 1ns/1ps
module dbg_rx_tb;
    localparam int BITCLK = 64;   // 16 ticks x 4 clocks per tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x;
    logic       rx_line = 1'b1;
    logic [2:0] parity_mode = 3'b000;
    logic       rd_en = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] rx_data;
    logic       st_ready, st_overrun, st_parity_err, st_frame_err;
    logic [1:0] tcnt = 2'd0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 2'd1;
    assign tick_16x = (tcnt == 2'd3);

    dbg_rx u_dut (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rx_line(rx_line),
        .parity_mode(parity_mode), .rd_en(rd_en), .clr_err(clr_err),
        .rx_data(rx_data), .st_ready(st_ready), .st_overrun(st_overrun),
        .st_parity_err(st_parity_err), .st_frame_err(st_frame_err)
    );

    // fields: mode[13:11] data[10:3] flip_par[2] stop[1] exp_fe[0]
    localparam logic [13:0] VEC [9] = '{
        {3'b000, 8'hA5, 1'b0, 1'b1, 1'b0},
        {3'b001, 8'h3C, 1'b0, 1'b1, 1'b0},
        {3'b010, 8'hFF, 1'b0, 1'b1, 1'b0},
        {3'b011, 8'h00, 1'b0, 1'b1, 1'b0},
        {3'b000, 8'h01, 1'b1, 1'b1, 1'b0},
        {3'b001, 8'h80, 1'b1, 1'b1, 1'b0},
        {3'b100, 8'h5A, 1'b1, 1'b1, 1'b0},
        {3'b111, 8'hC3, 1'b0, 1'b0, 1'b1},
        {3'b000, 8'h77, 1'b0, 1'b0, 1'b1}
    };

    function automatic logic want_par(input logic [2:0] m, input logic [7:0] d);
        case (m[1:0])
            2'b00:   return ^d;
            2'b01:   return ~^d;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [2:0] m, input logic [7:0] d,
                        input logic flip, input logic stop);
        parity_mode = m;
        hold_line(1'b0, BITCLK);
        for (int i = 0; i < 8; i++) hold_line(d[i], BITCLK);
        if (!m[2]) hold_line(want_par(m, d) ^ flip, BITCLK);
        hold_line(stop, BITCLK);
        hold_line(1'b1, 2 * BITCLK);
    endtask

    task automatic pulse_rd();
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10 reset state
        check("R10", "ready", st_ready, 0);
        check("R10", "overrun", st_overrun, 0);
        check("R10", "perr", st_parity_err, 0);
        check("R10", "ferr", st_frame_err, 0);
        check("R10", "data", rx_data, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table: R2 R3 R7 R8 R9
        for (int v = 0; v < 9; v++) begin
            logic [2:0] m;
            logic [7:0] d;
            logic exp_pe;
            m = VEC[v][13:11];
            d = VEC[v][10:3];
            exp_pe = !m[2] && VEC[v][2];
            send(m, d, VEC[v][2], VEC[v][1]);
            check("R3", "ready", st_ready, 1);
            check("R2", "data", rx_data, d);
            check(m[2] ? "R8" : "R7", "perr", st_parity_err, exp_pe);
            check("R9", "ferr", st_frame_err, VEC[v][0]);
            pulse_rd();
            check("R4", "ready after read", st_ready, 0);
            check("R4", "data after read", rx_data, d);
            pulse_clr();
            check("R6", "perr cleared", st_parity_err, 0);
            check("R6", "ferr cleared", st_frame_err, 0);
        end

        // R1: short low glitch is rejected
        hold_line(1'b0, 16);
        hold_line(1'b1, 3 * BITCLK);
        check("R1", "no char after glitch", st_ready, 0);
        check("R1", "data unchanged", rx_data, 8'h77);

        // R5: overrun, new char overwrites, ready stays
        send(3'b000, 8'h11, 1'b0, 1'b1);
        check("R5", "no overrun yet", st_overrun, 0);
        send(3'b000, 8'h22, 1'b0, 1'b1);
        check("R5", "overrun set", st_overrun, 1);
        check("R5", "ready stays", st_ready, 1);
        check("R5", "data overwritten", rx_data, 8'h22);
        pulse_rd();
        check("R4", "ready cleared", st_ready, 0);
        check("R6", "overrun sticky over read", st_overrun, 1);
        pulse_clr();
        check("R6", "overrun cleared", st_overrun, 0);

        // R6: clear does not touch ready or data
        send(3'b001, 8'h33, 1'b0, 1'b1);
        pulse_clr();
        check("R6", "ready kept by clear", st_ready, 1);
        check("R6", "data kept by clear", rx_data, 8'h33);
        pulse_rd();

        // R6/R7: parity error sticky across a good character
        send(3'b000, 8'h0F, 1'b1, 1'b1);
        check("R7", "perr set", st_parity_err, 1);
        pulse_rd();
        send(3'b000, 8'hF0, 1'b0, 1'b1);
        check("R6", "perr sticky", st_parity_err, 1);
        check("R2", "data", rx_data, 8'hF0);
        check("R5", "no overrun after read", st_overrun, 0);
        pulse_clr();
        check("R6", "perr cleared", st_parity_err, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule